// File: doc/BRIEF.md
# Exclusive Write-Back Level-One Data Cache

A two-way set-associative data cache with 64-byte lines sitting between a core-side load/store port and a second-level cache that never holds a copy of any line present here. Loads and stores that hit are pipelined one per cycle, and each response comes back a fixed three cycles after the request is taken. Stores are write-back: a store hit merges bytes into the line and marks it dirty. Nothing goes to the next level.

A miss stalls the core port and works through the miss in a fixed order. First, if the chosen way holds a line, that line goes down as a victim whether it is clean or dirty. The victim transfer carries the full line, its address and a dirty flag. Next, the cache asks the next level for the missing line and takes it as eight 64-bit beats. The stalled request then completes. A store miss allocates the line and then merges into it. A line that arrives from the next level is treated as having left that level, so it starts out clean in this cache.

Top module: `l1d_excl_cache`

## Requirements
- R1: After reset no line is valid: `req_ready` is 1, `rsp_valid`, `vic_valid` and `fill_req_valid` are 0, and the first access to any address misses.
- R2: A load hit returns the 64-bit word selected by address bits [5:3] (word k is line bits 64k+63..64k) on `rsp_data`, with `rsp_valid` high exactly three cycles after the cycle in which `req_valid && req_ready` was sampled. Hits are accepted on consecutive cycles.
- R3: A store hit writes byte b of `req_wdata` (bits 8b+7..8b) into the addressed word wherever `req_be[b]` is 1, marks the line dirty, causes no victim or fill traffic and raises `rsp_valid` three cycles after acceptance.
- R4: On a miss `req_ready` stays 0 until the miss completes. `fill_req_valid` presents the line-aligned address (bits [5:0] zero) and holds it until `fill_req_ready`.
- R5: A fill is eight beats on `fill_valid`/`fill_data`, with beat k forming line bits 64k+63..64k. Idle cycles may fall between beats. The stalled access responds three cycles after the cycle of the last beat.
- R6: A store miss allocates the line, then merges its bytes as in R3 and marks the line dirty.
- R7: The victim way is an invalid way if the set has one. Otherwise it is the least recently used way, where recency is set by every hit and every fill.
- R8: Every eviction, clean or dirty, presents the line-aligned victim address, the full line and its dirty flag on the victim port. It holds them until `vic_ready`, and finishes before the fill request is raised.
- R9: A line received from the next level starts clean: if it is evicted without any store to it, it leaves with `vic_dirty` 0.
- R10: A miss into a set with a free way produces no victim transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can take a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 40 | Byte address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| rsp_valid | output | 1 | Response for the oldest outstanding request |
| rsp_data | output | 64 | Load data (meaningful for loads) |
| vic_valid | output | 1 | Victim line offered to next level |
| vic_ready | input | 1 | Next level takes the victim |
| vic_addr | output | 40 | Line-aligned victim address |
| vic_dirty | output | 1 | Victim was modified here |
| vic_line | output | 512 | Victim line contents |
| fill_req_valid | output | 1 | Line request to next level |
| fill_req_ready | input | 1 | Next level accepts the request |
| fill_req_addr | output | 40 | Line-aligned address requested |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | 64 | Fill beat data |

## Verification
Single loads into a single set separate hits from misses. Filling both ways and then re-touching one shows whether the replacement choice follows recency rather than way number. Stores with partial byte masks, on hits and on misses, show the byte merge and tell clean evictions apart from dirty ones. Refetching an evicted line from the bench's next-level store shows that victim data makes the round trip intact. Runs of back-to-back hits across sets, plus fills with idle gaps between beats, pin the response timing in both the pipelined case and the stalled case.

// File: rtl/l1d_excl_cache.sv
module l1d_excl_cache #(
  parameter int ADDR_W     = 40,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [WORD_W/8-1:0]     req_be,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_data,
  output logic                    vic_valid,
  input  logic                    vic_ready,
  output logic [ADDR_W-1:0]       vic_addr,
  output logic                    vic_dirty,
  output logic [LINE_BYTES*8-1:0] vic_line,
  output logic                    fill_req_valid,
  input  logic                    fill_req_ready,
  output logic [ADDR_W-1:0]       fill_req_addr,
  input  logic                    fill_valid,
  input  logic [WORD_W-1:0]       fill_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WB     = WORD_W / 8;
  localparam int BEATS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(BEATS);
  localparam int BOFF_W = $clog2(WB);

  typedef enum logic [1:0] {IDLE, EVICT, ASK, FILL} st_t;
  st_t st;

  logic [TAG_W-1:0]  tag_q  [2][SETS];
  logic [LINE_W-1:0] line_q [2][SETS];
  logic [1:0]        vld_q  [SETS];
  logic [1:0]        dty_q  [SETS];
  logic [SETS-1:0]   lru_q;

  logic              s1_v, s1_wr, s2_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [WORD_W-1:0] s1_wdata, s2_data;
  logic [WB-1:0]     s1_be;
  logic              v_q;
  logic [WSEL_W-1:0] beat;
  logic [LINE_W-1:0] fbuf, fline;

  wire [IDX_W-1:0]  idx  = s1_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = s1_addr[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] wsel = s1_addr[BOFF_W +: WSEL_W];

  wire hit0 = vld_q[idx][0] && (tag_q[0][idx] == tag);
  wire hit1 = vld_q[idx][1] && (tag_q[1][idx] == tag);
  wire hit  = hit0 | hit1;
  wire hway = hit1;
  wire look_hit = s1_v && (st == IDLE) && hit;
  wire vway = !vld_q[idx][0] ? 1'b0 : (!vld_q[idx][1] ? 1'b1 : lru_q[idx]);
  wire fill_last = (st == FILL) && fill_valid && (beat == WSEL_W'(BEATS - 1));

  wire [LINE_W-1:0] hit_line = hway ? line_q[1][idx] : line_q[0][idx];
  wire [WORD_W-1:0] hit_word = hit_line[wsel*WORD_W +: WORD_W];

  assign req_ready = (st == IDLE) && !(s1_v && !hit);
  wire accept = req_valid && req_ready;

  assign vic_valid      = (st == EVICT);
  assign vic_addr       = {tag_q[v_q][idx], idx, {OFF_W{1'b0}}};
  assign vic_dirty      = dty_q[idx][v_q];
  assign vic_line       = line_q[v_q][idx];
  assign fill_req_valid = (st == ASK);
  assign fill_req_addr  = {tag, idx, {OFF_W{1'b0}}};

  always_comb begin
    fline = fbuf;
    fline[LINE_W-1 -: WORD_W] = fill_data;
  end

  function automatic logic [LINE_W-1:0] put_bytes(input logic [LINE_W-1:0] l,
      input logic [WSEL_W-1:0] ws, input logic [WORD_W-1:0] d, input logic [WB-1:0] m);
    for (int b = 0; b < WB; b++)
      if (m[b]) l[ws*WORD_W + b*8 +: 8] = d[b*8 +: 8];
    return l;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      rsp_valid <= 1'b0;
      v_q       <= 1'b0;
      beat      <= '0;
      lru_q     <= '0;
      for (int i = 0; i < SETS; i++) begin
        vld_q[i] <= '0;
        dty_q[i] <= '0;
      end
    end else begin
      s2_v      <= look_hit;
      rsp_valid <= s2_v;
      if (accept) s1_v <= 1'b1;
      else if (look_hit) s1_v <= 1'b0;
      case (st)
        IDLE:
          if (look_hit) begin
            lru_q[idx] <= ~hway;
            if (s1_wr) dty_q[idx][hway] <= 1'b1;
          end else if (s1_v) begin
            v_q <= vway;
            st  <= vld_q[idx][vway] ? EVICT : ASK;
          end
        EVICT:
          if (vic_ready) begin
            vld_q[idx][v_q] <= 1'b0;
            dty_q[idx][v_q] <= 1'b0;
            st <= ASK;
          end
        ASK:
          if (fill_req_ready) begin
            beat <= '0;
            st   <= FILL;
          end
        FILL:
          if (fill_valid) begin
            beat <= beat + 1'b1;
            if (fill_last) begin
              vld_q[idx][v_q] <= 1'b1;
              dty_q[idx][v_q] <= 1'b0;
              lru_q[idx]      <= ~v_q;
              st <= IDLE;
            end
          end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_wr    <= req_write;
      s1_addr  <= req_addr;
      s1_wdata <= req_wdata;
      s1_be    <= req_be;
    end
    s2_data  <= hit_word;
    rsp_data <= s2_data;
    if (look_hit && s1_wr)
      line_q[hway][idx] <= put_bytes(hit_line, wsel, s1_wdata, s1_be);
    if ((st == FILL) && fill_valid) begin
      fbuf[beat*WORD_W +: WORD_W] <= fill_data;
      if (fill_last) begin
        line_q[v_q][idx] <= fline;
        tag_q[v_q][idx]  <= tag;
      end
    end
  end

  // R8
  vic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_addr) && $stable(vic_dirty)));

  // R8
  vic_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_ready) |=> (!vld_q[idx][v_q] && !vic_valid));

  // R4
  fill_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

  // R4
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid || vic_valid) |-> !req_ready);

  // R2
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_hit |=> ##1 rsp_valid);

  // R7
  one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> $onehot0({hit1, hit0}));

  // R3
  dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> ((dty_q[idx] & ~vld_q[idx]) == 2'b00));
endmodule

// File: tb/l1d_excl_cache_tb.sv
module l1d_excl_cache_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 0, req_ready, req_write = 0;
  logic [39:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        vic_valid, vic_ready = 0, vic_dirty;
  logic [39:0] vic_addr;
  logic [511:0] vic_line;
  logic        fill_req_valid, fill_req_ready = 0;
  logic [39:0] fill_req_addr;
  logic        fill_valid = 0;
  logic [63:0] fill_data = '0;

  l1d_excl_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_addr(vic_addr),
    .vic_dirty(vic_dirty), .vic_line(vic_line),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr), .fill_valid(fill_valid), .fill_data(fill_data)
  );

  typedef struct { int cyc; logic [63:0] data; bit ld; string rq; } exp_t;
  exp_t eq[$];

  logic [511:0] l1d [logic [33:0]];
  bit           l1dirty [logic [33:0]];
  logic [33:0]  rec [64][$];
  logic [511:0] l2m [logic [33:0]];

  int cyc = 0;
  int nvec = 0, nbad = 0;
  bit running = 0, in_miss = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, string what, logic [511:0] act, logic [511:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [39:0] ad(int t, int s, int w);
    return {t[27:0], s[5:0], w[2:0], 3'b000};
  endfunction

  function automatic logic [511:0] mem_line(logic [33:0] la);
    logic [511:0] l;
    for (int w = 0; w < 8; w++) l[w*64 +: 64] = {la[31:0] ^ 32'h5A5A_C3C3, 24'h0, 8'(w)};
    return l;
  endfunction

  function automatic logic [511:0] merge(logic [511:0] l, int w, logic [63:0] d, logic [7:0] m);
    for (int b = 0; b < 8; b++) if (m[b]) l[w*64 + b*8 +: 8] = d[b*8 +: 8];
    return l;
  endfunction

  always @(negedge clk) begin
    if (running) begin
      bit e;
      while (eq.size() > 0 && eq[0].cyc < cyc) begin
        chk(0, eq[0].rq, "response missing", 0, 1);
        void'(eq.pop_front());
      end
      e = (eq.size() > 0) && (eq[0].cyc == cyc);
      chk(rsp_valid === e, e ? eq[0].rq : "R2", "rsp_valid", rsp_valid, e);
      if (e && rsp_valid && eq[0].ld)
        chk(rsp_data === eq[0].data, eq[0].rq, "rsp_data", rsp_data, eq[0].data);
      if (e) void'(eq.pop_front());
      if (!in_miss)
        chk(!vic_valid && !fill_req_valid, "R3", "traffic outside miss",
            {vic_valid, fill_req_valid}, 0);
    end
  end

  task automatic access(bit wr, logic [39:0] a, logic [63:0] d, logic [7:0] be, bit gap, string rq);
    logic [33:0] la = a[39:6];
    int s = int'(a[11:6]);
    int w = int'(a[5:3]);
    int acc, base, lim;
    bit hit;
    logic [33:0] vla;
    logic [511:0] ln;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    lim = 0;
    while (!req_ready && lim < 200) begin @(negedge clk); lim++; end
    acc = cyc;
    @(posedge clk); #1 req_valid = 0;
    hit = l1d.exists(la);
    if (hit) begin
      foreach (rec[s][i]) if (rec[s][i] == la) begin rec[s].delete(i); break; end
      rec[s].push_back(la);
      base = acc;
    end else begin
      in_miss = 1;
      if (rec[s].size() == 2) begin
        vla = rec[s].pop_front();
        lim = 0;
        @(negedge clk);
        while (!vic_valid && lim < 50) begin @(negedge clk); lim++; end
        chk(vic_valid, "R8", "victim offered", vic_valid, 1);
        chk(vic_addr === {vla, 6'b0}, "R8", "vic_addr", vic_addr, {vla, 6'b0});
        chk(vic_dirty === l1dirty[vla], l1dirty[vla] ? "R8" : "R9", "vic_dirty",
            vic_dirty, l1dirty[vla]);
        chk(vic_line === l1d[vla], "R8", "vic_line", vic_line, l1d[vla]);
        chk(!req_ready, "R4", "ready during victim", req_ready, 0);
        l2m[vla] = l1d[vla];
        l1d.delete(vla);
        l1dirty.delete(vla);
        vic_ready = 1;
        @(posedge clk); #1 vic_ready = 0;
      end
      lim = 0;
      @(negedge clk);
      while (!fill_req_valid && lim < 50) begin
        chk(!vic_valid, "R10", "unexpected victim", vic_valid, 0);
        @(negedge clk); lim++;
      end
      chk(!vic_valid, "R10", "victim with fill request", vic_valid, 0);
      chk(fill_req_valid, "R4", "fill request raised", fill_req_valid, 1);
      chk(fill_req_addr === {la, 6'b0}, "R4", "fill_req_addr", fill_req_addr, {la, 6'b0});
      chk(!req_ready, "R4", "ready during fill request", req_ready, 0);
      fill_req_ready = 1;
      @(posedge clk); #1 fill_req_ready = 0;
      if (l2m.exists(la)) begin ln = l2m[la]; l2m.delete(la); end
      else ln = mem_line(la);
      base = 0;
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        if (gap && (b == 3 || b == 6)) begin
          chk(!req_ready, "R5", "ready during fill gap", req_ready, 0);
          @(negedge clk);
        end
        fill_valid = 1; fill_data = ln[b*64 +: 64];
        if (b == 7) base = cyc;
        @(posedge clk); #1 fill_valid = 0;
      end
      l1d[la] = ln;
      l1dirty[la] = 0;
      rec[s].push_back(la);
      in_miss = 0;
    end
    if (wr) begin
      l1d[la] = merge(l1d[la], w, d, be);
      l1dirty[la] = 1;
    end
    eq.push_back('{base + 3, l1d[la][w*64 +: 64], !wr, rq});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(vic_valid === 1'b0 && fill_req_valid === 1'b0, "R1", "traffic after reset",
        {vic_valid, fill_req_valid}, 0);
    running = 1;

    access(0, ad(1, 5, 2), 0, 0, 1, "R1");
    access(0, ad(1, 5, 7), 0, 0, 0, "R2");
    access(0, ad(1, 5, 0), 0, 0, 0, "R2");
    access(0, ad(1, 5, 4), 0, 0, 0, "R2");
    access(1, ad(1, 5, 3), 64'h1122_3344_5566_7788, 8'h0F, 0, "R3");
    access(0, ad(1, 5, 3), 0, 0, 0, "R3");
    access(0, ad(2, 5, 0), 0, 0, 0, "R10");
    access(0, ad(1, 5, 1), 0, 0, 0, "R7");
    access(0, ad(3, 5, 6), 0, 0, 1, "R9");
    access(0, ad(4, 5, 0), 0, 0, 0, "R8");
    access(1, ad(7, 9, 1), 64'hDEAD_BEEF_CAFE_F00D, 8'hF0, 0, "R6");
    access(0, ad(7, 9, 1), 0, 0, 0, "R6");
    access(0, ad(1, 5, 3), 0, 0, 1, "R5");
    access(0, ad(2, 5, 2), 0, 0, 0, "R7");
    for (int i = 0; i < 12; i++)
      access(i[0], ad(20 + (i % 3), 30 + (i % 4), i % 8), 64'h0F0F_0000_0000_0000 + 64'(i),
             8'(8'h81 << (i % 4)), i[1], "R2");
    access(0, ad(8, 9, 0), 0, 0, 0, "R7");
    access(0, ad(9, 9, 0), 0, 0, 0, "R8");
    access(0, ad(7, 9, 1), 0, 0, 1, "R6");
    repeat (8) @(negedge clk);
    chk(eq.size() == 0, "R2", "responses outstanding", eq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule